// File: doc/BRIEF.md
# Dual-Clock FIFO with Sticky Error Flag

This block moves data words from a producer running on one clock to a consumer running on a second, unrelated clock. The producer presents a word with a write request and watches `full`. The consumer raises a read request while `empty` is low and receives the oldest stored word on the read clock edge that accepts the request. Word width and entry count are parameters. The entry count must be a power of two.

Each side keeps a binary pointer one bit wider than the storage index. The extra top bit is the wrap toggle, and it inverts every time the index rolls over from the last entry to entry zero. Each pointer is registered in Gray code and passes through a two-flop synchronizer into the other domain. The full flag is computed in the write domain and the empty flag in the read domain, each from its own pointer and the synchronized copy of the other pointer. Both flags can therefore stay asserted a few cycles longer than necessary, but they never release early.

A request that cannot be honoured is dropped. This covers a write while full and a read while empty. Either case sets a sticky `error` output that only the asynchronous reset clears.

Top module: `dual_clock_fifo`

## Requirements
- R1: Every accepted word is delivered exactly once and in the order it was written, including across several wraps of both pointers with the two clocks running at unrelated rates.
- R2: While and after the asynchronous reset `rst` is high, `empty` is 1, `full` is 0, `error` is 0 and `rd_data` is 0.
- R3: After a word is accepted into an empty FIFO, `empty` falls after two or three read clock edges, counted from the accepting write edge.
- R4: With no reads, `full` is 0 after DEPTH-1 accepted writes and is 1 after DEPTH accepted writes.
- R5: A write while `full` is 1 is dropped. The stored contents stay unchanged, so draining returns only the DEPTH earlier words and then `empty` rises again.
- R6: A read while `empty` is 1 is dropped, and `rd_data` keeps its previous value.
- R7: A dropped write or a dropped read sets `error` to 1. It stays 1 through any later traffic and returns to 0 only on reset.
- R8: `rd_data` changes only on a read clock edge where `rd_en` is 1 and `empty` is 0. On that edge it shows the oldest stored word.
- R9: After a read frees an entry of a full FIFO, `full` falls within one to four write clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock, unrelated to wr_clk |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | No free entry, as seen from the write domain |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered output word |
| empty | output | 1 | No stored word, as seen from the read domain |
| error | output | 1 | Sticky flag for a dropped write or a dropped read |

## Verification
The main data path is tried with three input patterns, each against a reference queue.

- Back-to-back writes and reads. This checks the pipelined read path and pointer wrap at full throughput.
- Irregular enable patterns on both sides. These let the occupancy drift, so the flags toggle at many pointer phases.
- Bursts that fill the buffer completely before draining. These separate the full condition from the empty condition, which differ only in the toggle bit.

Flag latency is measured in clock edges, to separate a correct two-flop crossing from a missing or an extra stage. Deliberate overflow and underflow show that a dropped request leaves storage and output untouched while still setting the sticky error.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  localparam int SYNC_STAGES = 2;

  // Gray encoding of a binary count: neighbours differ in one bit.
  function automatic logic [31:0] bin_to_gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Inverse: each binary bit is the XOR of all Gray bits at or above it.
  function automatic logic [31:0] gray_to_bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ptr_ctl.sv
module dcf_ptr_ctl
  import dcf_pkg::*;
#(
  parameter int AW       = 3,
  parameter int PW       = AW + 1,
  parameter bit IS_WRITE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [PW-1:0] peer_gray,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] gray,
  output logic          blocked,
  output logic          accept,
  output logic          reject,
  output logic          err
);
  logic [PW-1:0] ptr_q, gray_q, ptr_nx, peer_bin;
  logic          err_q, idx_eq, tog_eq;

  assign peer_bin = PW'(gray_to_bin(32'(peer_gray)));
  assign idx_eq   = (ptr_q[AW-1:0] == peer_bin[AW-1:0]);
  assign tog_eq   = (ptr_q[AW] == peer_bin[AW]);

  generate
    if (IS_WRITE) begin : g_full
      assign blocked = idx_eq && !tog_eq;
    end else begin : g_empty
      assign blocked = idx_eq && tog_eq;
    end
  endgenerate

  assign accept = req && !blocked;
  assign reject = req && blocked;
  assign ptr_nx = ptr_q + PW'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ptr_q  <= '0;
      gray_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (accept) begin
        ptr_q  <= ptr_nx;
        gray_q <= PW'(bin_to_gray(32'(ptr_nx)));
      end
      if (reject) err_q <= 1'b1;
    end
  end

  assign ptr  = ptr_q;
  assign gray = gray_q;
  assign err  = err_q;
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk or posedge rst) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             error
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;

  // Named internal events, visible to the bound checker.
  logic [PW-1:0] wr_ptr, wr_gray, rd_ptr, rd_gray;
  logic [PW-1:0] wr_gray_at_rd, rd_gray_at_wr;
  logic          wr_ok, wr_rej, rd_ok, rd_rej, wr_err, rd_err;

  dcf_ptr_ctl #(.AW(AW), .PW(PW), .IS_WRITE(1'b1)) u_wctl (
    .clk(wr_clk), .rst(rst), .req(wr_en), .peer_gray(rd_gray_at_wr),
    .ptr(wr_ptr), .gray(wr_gray), .blocked(full),
    .accept(wr_ok), .reject(wr_rej), .err(wr_err)
  );

  dcf_ptr_ctl #(.AW(AW), .PW(PW), .IS_WRITE(1'b0)) u_rctl (
    .clk(rd_clk), .rst(rst), .req(rd_en), .peer_gray(wr_gray_at_rd),
    .ptr(rd_ptr), .gray(rd_gray), .blocked(empty),
    .accept(rd_ok), .reject(rd_rej), .err(rd_err)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst(rst), .d(wr_gray), .q(wr_gray_at_rd)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst(rst), .d(rd_gray), .q(rd_gray_at_wr)
  );

  dcf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
    .we(wr_ok), .waddr(wr_ptr[AW-1:0]), .wdata(wr_data),
    .re(rd_ok), .raddr(rd_ptr[AW-1:0]), .rdata(rd_data)
  );

  assign error = wr_err | rd_err;
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int WIDTH = 16,
  parameter int PW    = 4
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic             full,
  input logic             empty,
  input logic             error,
  input logic [WIDTH-1:0] rd_data,
  input logic [PW-1:0]    wr_ptr,
  input logic [PW-1:0]    wr_gray,
  input logic [PW-1:0]    rd_gray
);
  a_r4_wr_step: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && !full) |=> (wr_ptr == PW'($past(wr_ptr) + 1'b1)));

  a_r5_full_drops: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && full) |=> $stable(wr_ptr));

  a_r7_overflow_flag: assert property (@(posedge wr_clk) disable iff (rst)
    (wr_en && full) |=> error);

  a_r7_underflow_flag: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_en && empty) |=> error);

  a_r7_sticky: assert property (@(posedge wr_clk) disable iff (rst)
    error |=> error);

  a_r6_empty_hold: assert property (@(posedge rd_clk) disable iff (rst)
    (rd_en && empty) |=> $stable(rd_data));

  a_r8_idle_hold: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r3_wgray_step: assert property (@(posedge wr_clk) disable iff (rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  a_r9_rgray_step: assert property (@(posedge rd_clk) disable iff (rst)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind dual_clock_fifo dcf_checker #(.WIDTH(WIDTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .full(full), .empty(empty), .error(error), .rd_data(rd_data),
  .wr_ptr(wr_ptr), .wr_gray(wr_gray), .rd_gray(rd_gray)
);

// File: tb/dual_clock_fifo_tb.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb;
  localparam int WIDTH = 16;
  localparam int DEPTH = 8;

  logic             wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             full, empty, error;

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] exp_q[$];
  logic [WIDTH-1:0] next_val = 16'h1000;

  always #4.0  wr_clk = ~wr_clk;   // 125 MHz
  always #5.65 rd_clk = ~rd_clk;   // unrelated read clock

  dual_clock_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en),
    .wr_data(wr_data), .full(full), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .error(error)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  // Driver: writes n words, pushing each accepted one into the reference queue.
  task automatic push_words(int n, bit gaps, logic [15:0] seed);
    int sent = 0;
    logic [15:0] l = seed;
    while (sent < n) begin
      @(negedge wr_clk);
      l = lfsr(l);
      if (!full && (!gaps || l[0] || l[3])) begin
        wr_en = 1'b1; wr_data = next_val;
        exp_q.push_back(next_val);
        next_val++; sent++;
      end else wr_en = 1'b0;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  // Monitor: reads n words and compares each with the reference queue (R1, R8).
  task automatic pull_words(int n, bit gaps, logic [15:0] seed);
    int got = 0;
    bit pending = 1'b0;
    logic [15:0] l = seed;
    logic [WIDTH-1:0] e;
    while (got < n) begin
      @(negedge rd_clk);
      if (pending) begin
        if (exp_q.size() == 0) check(1'b0, "R1", "read with empty reference", int'(rd_data), 0);
        else begin
          e = exp_q.pop_front();
          check(rd_data == e, "R1", "word order", int'(rd_data), int'(e));
        end
        got++;
      end
      pending = 1'b0;
      l = lfsr(l);
      if (got < n && !empty && (!gaps || l[1] || l[4])) begin
        rd_en = 1'b1; pending = 1'b1;
      end else rd_en = 1'b0;
    end
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge wr_clk); rst = 1'b1;
    repeat (3) @(negedge rd_clk);
    @(negedge wr_clk); rst = 1'b0;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    logic [WIDTH-1:0] hold;
    // R2: reset state
    repeat (3) @(negedge wr_clk);
    check(empty == 1'b1, "R2", "empty in reset", int'(empty), 1);
    check(full == 1'b0, "R2", "full in reset", int'(full), 0);
    check(error == 1'b0, "R2", "error in reset", int'(error), 0);
    check(rd_data == '0, "R2", "rd_data in reset", int'(rd_data), 0);
    @(negedge wr_clk); rst = 1'b0;
    repeat (3) @(negedge rd_clk);
    check(empty == 1'b1 && full == 1'b0 && error == 1'b0, "R2", "flags after reset",
          int'({empty, full, error}), 3'b100);

    // R3: empty latency after a single write
    @(negedge wr_clk);
    wr_en = 1'b1; wr_data = next_val; exp_q.push_back(next_val); next_val++;
    @(posedge wr_clk); #0.1;
    wr_en = 1'b0;
    n = 0;
    while (empty && n < 10) begin @(negedge rd_clk); n++; end
    check(n >= 2 && n <= 3, "R3", "read edges until empty falls", n, 2);
    // R8: data appears on the accepting read edge
    pull_words(1, 1'b0, 16'h1);
    check(error == 1'b0, "R8", "no error after a legal read", int'(error), 0);

    // R1: back-to-back, then irregular enables
    fork
      push_words(40, 1'b0, 16'h0);
      pull_words(40, 1'b0, 16'h0);
    join
    fork
      push_words(60, 1'b1, 16'hACE1);
      pull_words(60, 1'b1, 16'h5A5A);
    join
    check(exp_q.size() == 0, "R1", "reference drained", exp_q.size(), 0);
    check(error == 1'b0, "R1", "no error in legal traffic", int'(error), 0);

    // R4: fill
    push_words(DEPTH - 1, 1'b0, 16'h0);
    check(full == 1'b0, "R4", "full after DEPTH-1 writes", int'(full), 0);
    push_words(1, 1'b0, 16'h0);
    check(full == 1'b1, "R4", "full after DEPTH writes", int'(full), 1);

    // R5/R7: overflow attempt
    @(negedge wr_clk); wr_en = 1'b1; wr_data = 16'hDEAD;
    @(negedge wr_clk); wr_en = 1'b0;
    check(error == 1'b1, "R7", "error after overflow", int'(error), 1);
    check(full == 1'b1, "R5", "still full after dropped write", int'(full), 1);

    // R9: full release latency
    pull_words(1, 1'b0, 16'h0);
    n = 0;
    while (full && n < 10) begin @(negedge wr_clk); n++; end
    check(n >= 1 && n <= 4, "R9", "write edges until full falls", n, 3);

    // R5: drain, only the original words come out
    pull_words(DEPTH - 1, 1'b0, 16'h0);
    repeat (4) @(negedge rd_clk);
    check(empty == 1'b1, "R5", "empty after draining DEPTH words", int'(empty), 1);
    check(exp_q.size() == 0, "R5", "reference drained", exp_q.size(), 0);

    // R6: underflow leaves rd_data
    @(negedge rd_clk); hold = rd_data; rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    check(rd_data == hold, "R6", "rd_data after dropped read", int'(rd_data), int'(hold));
    check(empty == 1'b1, "R6", "empty after dropped read", int'(empty), 1);
    check(error == 1'b1, "R7", "error still set", int'(error), 1);

    // R7: reset clears, underflow alone sets
    do_reset();
    check(error == 1'b0, "R7", "error cleared by reset", int'(error), 0);
    check(empty == 1'b1 && full == 1'b0, "R2", "flags after second reset",
          int'({empty, full}), 2'b10);
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    check(error == 1'b1, "R7", "error after underflow", int'(error), 1);
    do_reset();

    // R1: multiple wraps with bursts
    fork
      push_words(5 * DEPTH, 1'b0, 16'h0);
      begin repeat (20) @(negedge rd_clk); pull_words(5 * DEPTH, 1'b1, 16'h7777); end
    join
    check(exp_q.size() == 0, "R1", "reference drained after wraps", exp_q.size(), 0);
    check(error == 1'b0, "R1", "no error after wraps", int'(error), 0);

    finish_run();
  end
endmodule